// File: doc/BRIEF.md
# Tagged circular register stack

This block holds eight floating-point-width data entries that are used as a stack. It stores no top-of-stack contents in fixed places. Each entry sits in a physical slot, and a 3-bit top pointer picks which slot is the current top. Software-visible entries are named by a stack-relative index `i` from 0 to 7. Index 0 is the top, and the physical slot is `(top + i) mod 8`. Each slot carries a tag bit that records whether it holds a valid value or is empty.

The block takes one command per clock cycle when `cmd_valid` is high. Every command completes on that single clock edge, and there is no back-pressure. The commands cover the following:
- push and pop, including a double pop
- rotating the pointer either way without touching the tags
- freeing an entry, and free-then-pop
- exchanging the top with another entry
- writing an entry
- copying the top to an entry and then popping
- re-initialising the stack

Two read ports are addressed relative to the top. They return the data and the tag without delay. A read strobe on each port lets the read count toward stack-underflow detection. Overflow and underflow are reported as sticky flags. The top pointer is exported so that it can be placed in a status word.

Top module: `tagged_reg_stack`

## Requirements
- R1: After `rst_n` low, or after command code 12 (re-initialise), the top pointer is 0, all eight tags are empty and both flags are clear. Command code 12 leaves the stored data unchanged.
- R2: Read ports A and B return the data and the tag of slot `(top + idx) mod 8` in the same cycle, with no register in the path.
- R3: Push (code 1) decrements the top pointer, writes `cmd_wdata` into the new index 0 and marks it valid. If that slot was already valid, the overflow flag is set and the push still completes.
- R4: Pop (code 2) marks index 0 empty and increments the top pointer. Double pop (code 3) marks indices 0 and 1 empty and adds 2 to the pointer. The underflow flag is set if any entry popped was already empty. Data is kept.
- R5: Increment (code 4) and decrement (code 5) change the top pointer by +1 and -1 and leave every tag as it was.
- R6: Free (code 6) marks index `cmd_idx` empty. Free-and-pop (code 7) marks index `cmd_idx` empty, then also marks index 0 empty and increments the pointer.
- R7: Exchange (code 8) swaps the data and the tags of index 0 and index `cmd_idx`. Exchange-one (code 9) swaps index 0 and index 1. Either one sets the underflow flag if one of the two entries was empty.
- R8: Write (code 10) stores `cmd_wdata` at index `cmd_idx` and marks it valid. Store-and-pop (code 11) copies index 0 into index `cmd_idx`, numbered before the pop, marks that entry valid and then pops. It sets underflow if index 0 was empty.
- R9: The flags are sticky and only R1 clears them. A read strobe (`rd_a_en` or `rd_b_en`) on an empty entry sets the underflow flag on the next edge, and an unstrobed read never does. When a clear and a new event fall in the same cycle, the clear wins.
- R10: When `cmd_valid` is low, or when the code is 0 or 13 to 15, the top pointer, the tags and the data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken on the next rising edge |
| cmd_op | input | 4 | Command code |
| cmd_idx | input | 3 | Stack-relative operand index |
| cmd_wdata | input | DATA_W | Data for push and write |
| rd_a_en | input | 1 | Read strobe for port A (underflow detection) |
| rd_a_idx | input | 3 | Stack-relative index for port A |
| rd_a_data | output | DATA_W | Port A data |
| rd_a_tag | output | 1 | Port A tag, 1 = valid |
| rd_b_en | input | 1 | Read strobe for port B |
| rd_b_idx | input | 3 | Stack-relative index for port B |
| rd_b_data | output | DATA_W | Port B data |
| rd_b_tag | output | 1 | Port B tag, 1 = valid |
| top_ptr | output | 3 | Current top-of-stack pointer |
| stack_overflow | output | 1 | Sticky overflow flag |
| stack_underflow | output | 1 | Sticky underflow flag |

## Verification
A wrong top pointer shows on `top_ptr` one edge after the command. It also shows at once on the read ports, because every later index then reads the wrong slot. A bad tag update shows as a wrong `rd_a_tag` in the cycle after the command. It can also show later as a spurious or missing flag, on the first push or pop that reaches that slot, which may be several commands later. Data corruption from a mis-steered exchange or store-and-pop shows only when that entry is read back. For that reason the stimulus reads the moved entries immediately and reads them again after the pointer has been rotated.

// File: rtl/tstk_pkg.sv
`timescale 1ns/1ps
package tstk_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_PUSH  = 4'd1,
    OP_POP   = 4'd2,
    OP_POP2  = 4'd3,
    OP_INC   = 4'd4,
    OP_DEC   = 4'd5,
    OP_FREE  = 4'd6,
    OP_FREEP = 4'd7,
    OP_XCH   = 4'd8,
    OP_XCH1  = 4'd9,
    OP_WRITE = 4'd10,
    OP_STP   = 4'd11,
    OP_RESET = 4'd12
  } stk_op_e;
endpackage

// File: rtl/tstk_ctrl.sv
`timescale 1ns/1ps
module tstk_ctrl
  import tstk_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic                            cmd_valid,
  input  logic [OP_W-1:0]                 cmd_op,
  input  logic [PTR_W-1:0]                cmd_idx,
  input  logic [DATA_W-1:0]               cmd_wdata,
  input  logic [PTR_W-1:0]                top_q,
  input  logic [DEPTH-1:0]                tag_q,
  input  logic [DEPTH-1:0][DATA_W-1:0]    slot_q,
  input  logic                            rd_a_en,
  input  logic [PTR_W-1:0]                rd_a_slot,
  input  logic                            rd_b_en,
  input  logic [PTR_W-1:0]                rd_b_slot,
  output logic [PTR_W-1:0]                top_nxt,
  output logic [DEPTH-1:0]                tag_nxt,
  output logic                            we0,
  output logic [PTR_W-1:0]                wslot0,
  output logic [DATA_W-1:0]               wd0,
  output logic                            we1,
  output logic [PTR_W-1:0]                wslot1,
  output logic [DATA_W-1:0]               wd1,
  output logic                            ovf_evt,
  output logic                            unf_evt,
  output logic                            clr_flags
);
  stk_op_e          op;
  logic [PTR_W-1:0] s_top, s_one, s_two, s_dn, s_idx, s_x;

  assign op    = stk_op_e'(cmd_op);
  assign s_top = top_q;
  assign s_one = top_q + PTR_W'(1);
  assign s_two = top_q + PTR_W'(2);
  assign s_dn  = top_q - PTR_W'(1);
  assign s_idx = top_q + cmd_idx;
  assign s_x   = (op == OP_XCH1) ? s_one : s_idx;

  always_comb begin
    top_nxt   = top_q;
    tag_nxt   = tag_q;
    we0       = 1'b0;
    wslot0    = s_top;
    wd0       = cmd_wdata;
    we1       = 1'b0;
    wslot1    = s_top;
    wd1       = cmd_wdata;
    ovf_evt   = 1'b0;
    clr_flags = 1'b0;
    unf_evt   = (rd_a_en && !tag_q[rd_a_slot]) || (rd_b_en && !tag_q[rd_b_slot]);
    if (cmd_valid) begin
      case (op)
        OP_PUSH: begin
          top_nxt       = s_dn;
          tag_nxt[s_dn] = 1'b1;
          we0           = 1'b1;
          wslot0        = s_dn;
          ovf_evt       = tag_q[s_dn];
        end
        OP_POP: begin
          tag_nxt[s_top] = 1'b0;
          top_nxt        = s_one;
          if (!tag_q[s_top]) unf_evt = 1'b1;
        end
        OP_POP2: begin
          tag_nxt[s_top] = 1'b0;
          tag_nxt[s_one] = 1'b0;
          top_nxt        = s_two;
          if (!tag_q[s_top] || !tag_q[s_one]) unf_evt = 1'b1;
        end
        OP_INC: top_nxt = s_one;
        OP_DEC: top_nxt = s_dn;
        OP_FREE: tag_nxt[s_idx] = 1'b0;
        OP_FREEP: begin
          tag_nxt[s_idx] = 1'b0;
          tag_nxt[s_top] = 1'b0;
          top_nxt        = s_one;
        end
        OP_XCH, OP_XCH1: begin
          we0            = 1'b1;
          wslot0         = s_top;
          wd0            = slot_q[s_x];
          we1            = 1'b1;
          wslot1         = s_x;
          wd1            = slot_q[s_top];
          tag_nxt[s_top] = tag_q[s_x];
          tag_nxt[s_x]   = tag_q[s_top];
          if (!tag_q[s_top] || !tag_q[s_x]) unf_evt = 1'b1;
        end
        OP_WRITE: begin
          we0            = 1'b1;
          wslot0         = s_idx;
          tag_nxt[s_idx] = 1'b1;
        end
        OP_STP: begin
          we0            = 1'b1;
          wslot0         = s_idx;
          wd0            = slot_q[s_top];
          tag_nxt[s_idx] = 1'b1;
          tag_nxt[s_top] = 1'b0;
          top_nxt        = s_one;
          if (!tag_q[s_top]) unf_evt = 1'b1;
        end
        OP_RESET: begin
          top_nxt   = '0;
          tag_nxt   = '0;
          clr_flags = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tstk_state.sv
`timescale 1ns/1ps
module tstk_state #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] top_nxt,
  input  logic [DEPTH-1:0] tag_nxt,
  input  logic             ovf_evt,
  input  logic             unf_evt,
  input  logic             clr_flags,
  output logic [PTR_W-1:0] top_q,
  output logic [DEPTH-1:0] tag_q,
  output logic             ovf_q,
  output logic             unf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      tag_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      top_q <= top_nxt;
      tag_q <= tag_nxt;
      if (clr_flags) begin
        ovf_q <= 1'b0;
        unf_q <= 1'b0;
      end else begin
        if (ovf_evt) ovf_q <= 1'b1;
        if (unf_evt) unf_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tstk_datafile.sv
`timescale 1ns/1ps
module tstk_datafile #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         we0,
  input  logic [PTR_W-1:0]             wslot0,
  input  logic [DATA_W-1:0]            wd0,
  input  logic                         we1,
  input  logic [PTR_W-1:0]             wslot1,
  input  logic [DATA_W-1:0]            wd1,
  output logic [DEPTH-1:0][DATA_W-1:0] slot_q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (we1 && wslot1 == PTR_W'(g))      cell_q <= wd1;
      else if (we0 && wslot0 == PTR_W'(g)) cell_q <= wd0;
    end
    assign slot_q[g] = cell_q;
  end
endmodule

// File: rtl/tagged_reg_stack.sv
`timescale 1ns/1ps
module tagged_reg_stack
  import tstk_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [PTR_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              rd_a_en,
  input  logic [PTR_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic              rd_a_tag,
  input  logic              rd_b_en,
  input  logic [PTR_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              rd_b_tag,
  output logic [PTR_W-1:0]  top_ptr,
  output logic              stack_overflow,
  output logic              stack_underflow
);
  logic [PTR_W-1:0]             top_q, top_nxt;
  logic [DEPTH-1:0]             tag_q, tag_nxt;
  logic [DEPTH-1:0][DATA_W-1:0] slot_q;
  logic                         we0, we1, ovf_evt, unf_evt, clr_flags;
  logic [PTR_W-1:0]             wslot0, wslot1, rd_a_slot, rd_b_slot;
  logic [DATA_W-1:0]            wd0, wd1;

  assign rd_a_slot = top_q + rd_a_idx;
  assign rd_b_slot = top_q + rd_b_idx;
  assign rd_a_data = slot_q[rd_a_slot];
  assign rd_a_tag  = tag_q[rd_a_slot];
  assign rd_b_data = slot_q[rd_b_slot];
  assign rd_b_tag  = tag_q[rd_b_slot];
  assign top_ptr   = top_q;

  tstk_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata),
    .top_q(top_q), .tag_q(tag_q), .slot_q(slot_q),
    .rd_a_en(rd_a_en), .rd_a_slot(rd_a_slot), .rd_b_en(rd_b_en), .rd_b_slot(rd_b_slot),
    .top_nxt(top_nxt), .tag_nxt(tag_nxt),
    .we0(we0), .wslot0(wslot0), .wd0(wd0), .we1(we1), .wslot1(wslot1), .wd1(wd1),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt), .clr_flags(clr_flags)
  );

  tstk_state #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_state (
    .clk(clk), .rst_n(rst_n), .top_nxt(top_nxt), .tag_nxt(tag_nxt),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt), .clr_flags(clr_flags),
    .top_q(top_q), .tag_q(tag_q), .ovf_q(stack_overflow), .unf_q(stack_underflow)
  );

  tstk_datafile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_data (
    .clk(clk), .we0(we0), .wslot0(wslot0), .wd0(wd0),
    .we1(we1), .wslot1(wslot1), .wd1(wd1), .slot_q(slot_q)
  );
endmodule

// File: rtl/tagged_reg_stack_chk.sv
`timescale 1ns/1ps
module tagged_reg_stack_chk
  import tstk_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [OP_W-1:0]  cmd_op,
  input logic             rd_a_en,
  input logic             rd_b_en,
  input logic [PTR_W-1:0] top_ptr,
  input logic [DEPTH-1:0] tag_q,
  input logic             ovf,
  input logic             unf
);
  // R1
  reinit_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_RESET |=> top_ptr == '0 && tag_q == '0 && !ovf && !unf);

  // R3
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_PUSH |=> top_ptr == $past(top_ptr) - PTR_W'(1));

  // R3
  push_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_PUSH |=> tag_q[top_ptr]);

  // R4
  pop_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_POP |=> top_ptr == $past(top_ptr) + PTR_W'(1));

  // R4
  pop_empty_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_POP && !tag_q[top_ptr] |=> unf);

  // R5
  rotate_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_INC || cmd_op == OP_DEC) |=> $stable(tag_q));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(cmd_valid && cmd_op == OP_RESET) |=> ovf);

  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf && !(cmd_valid && cmd_op == OP_RESET) |=> unf);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && !rd_a_en && !rd_b_en |=> $stable(top_ptr) && $stable(tag_q) && $stable(unf));
endmodule

bind tagged_reg_stack tagged_reg_stack_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rd_a_en(rd_a_en), .rd_b_en(rd_b_en), .top_ptr(top_ptr), .tag_q(tag_q),
  .ovf(stack_overflow), .unf(stack_underflow)
);

// File: tb/tagged_reg_stack_bench.sv
`timescale 1ns/1ps
module tagged_reg_stack_bench;
  import tstk_pkg::*;

  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [3:0]    cmd_op = '0;
  logic [2:0]    cmd_idx = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rd_a_en = 1'b0, rd_b_en = 1'b0;
  logic [2:0]    rd_a_idx = '0, rd_b_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic          rd_a_tag, rd_b_tag;
  logic [2:0]    top_ptr;
  logic          stack_overflow, stack_underflow;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tagged_reg_stack #(.DATA_W(DW), .DEPTH(8)) u_tagged_reg_stack (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata),
    .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_tag(rd_a_tag),
    .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_tag(rd_b_tag),
    .top_ptr(top_ptr), .stack_overflow(stack_overflow), .stack_underflow(stack_underflow)
  );

  typedef struct packed {
    logic [3:0]    op;
    logic [2:0]    idx;
    logic [DW-1:0] wd;
    logic [2:0]    ridx;
    logic [2:0]    etop;
    logic          etag;
    logic [DW-1:0] edata;
    logic          cd;
    logic          eovf;
    logic          eunf;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  3'd0, 64'hA1, 3'd0, 3'd7, 1'b1, 64'hA1, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 push
    '{4'd1,  3'd0, 64'hB2, 3'd1, 3'd6, 1'b1, 64'hA1, 1'b1, 1'b0, 1'b0, 8'd2},  // R2 relative read
    '{4'd1,  3'd0, 64'hC3, 3'd0, 3'd5, 1'b1, 64'hC3, 1'b1, 1'b0, 1'b0, 8'd3},  // R3
    '{4'd8,  3'd2, 64'h0,  3'd0, 3'd5, 1'b1, 64'hA1, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 exchange idx 2
    '{4'd9,  3'd0, 64'h0,  3'd0, 3'd5, 1'b1, 64'hB2, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 exchange-one
    '{4'd10, 3'd4, 64'hD4, 3'd4, 3'd5, 1'b1, 64'hD4, 1'b1, 1'b0, 1'b0, 8'd8},  // R8 write
    '{4'd4,  3'd0, 64'h0,  3'd7, 3'd6, 1'b1, 64'hB2, 1'b1, 1'b0, 1'b0, 8'd5},  // R5 inc keeps tag
    '{4'd5,  3'd0, 64'h0,  3'd0, 3'd5, 1'b1, 64'hB2, 1'b1, 1'b0, 1'b0, 8'd5},  // R5 dec
    '{4'd2,  3'd0, 64'h0,  3'd7, 3'd6, 1'b0, 64'h0,  1'b0, 1'b0, 1'b0, 8'd4},  // R4 pop tags empty
    '{4'd5,  3'd0, 64'h0,  3'd0, 3'd5, 1'b0, 64'hB2, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 data kept
    '{4'd4,  3'd0, 64'h0,  3'd0, 3'd6, 1'b1, 64'hA1, 1'b1, 1'b0, 1'b0, 8'd5},  // R5
    '{4'd11, 3'd3, 64'h0,  3'd2, 3'd7, 1'b1, 64'hA1, 1'b1, 1'b0, 1'b0, 8'd8},  // R8 store-and-pop
    '{4'd6,  3'd2, 64'h0,  3'd2, 3'd7, 1'b0, 64'hA1, 1'b1, 1'b0, 1'b0, 8'd6},  // R6 free
    '{4'd1,  3'd0, 64'hE5, 3'd0, 3'd6, 1'b1, 64'hE5, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 into empty slot
    '{4'd7,  3'd1, 64'h0,  3'd0, 3'd7, 1'b0, 64'hC3, 1'b1, 1'b0, 1'b0, 8'd6},  // R6 free-and-pop
    '{4'd2,  3'd0, 64'h0,  3'd0, 3'd0, 1'b0, 64'h0,  1'b0, 1'b0, 1'b1, 8'd4},  // R4 pop of empty
    '{4'd12, 3'd0, 64'h0,  3'd1, 3'd0, 1'b0, 64'hA1, 1'b1, 1'b0, 1'b0, 8'd1},  // R1 re-init keeps data
    '{4'd1,  3'd0, 64'h11, 3'd0, 3'd7, 1'b1, 64'h11, 1'b1, 1'b0, 1'b0, 8'd3},  // R3
    '{4'd1,  3'd0, 64'h22, 3'd0, 3'd6, 1'b1, 64'h22, 1'b1, 1'b0, 1'b0, 8'd3},  // R3
    '{4'd3,  3'd0, 64'h0,  3'd6, 3'd0, 1'b0, 64'h22, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 double pop
    '{4'd13, 3'd0, 64'h99, 3'd6, 3'd0, 1'b0, 64'h22, 1'b1, 1'b0, 1'b0, 8'd10}  // R10 unused code
  };

  task automatic chk(input int req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [3:0] op, input logic [2:0] idx, input logic [DW-1:0] wd);
    cmd_op    = op;
    cmd_idx   = idx;
    cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(1, "reset top", DW'(top_ptr), 0);
    chk(1, "reset tag", DW'(rd_a_tag), 0);
    chk(1, "reset ovf", DW'(stack_overflow), 0);
    chk(1, "reset unf", DW'(stack_underflow), 0);

    for (int v = 0; v < NV; v++) begin
      rd_a_idx = VECS[v].ridx;
      do_cmd(VECS[v].op, VECS[v].idx, VECS[v].wd);
      chk(VECS[v].req, $sformatf("vec%0d top", v), DW'(top_ptr), DW'(VECS[v].etop));
      chk(VECS[v].req, $sformatf("vec%0d tag", v), DW'(rd_a_tag), DW'(VECS[v].etag));
      if (VECS[v].cd) chk(VECS[v].req, $sformatf("vec%0d data", v), rd_a_data, VECS[v].edata);
      chk(VECS[v].req, $sformatf("vec%0d ovf", v), DW'(stack_overflow), DW'(VECS[v].eovf));
      chk(VECS[v].req, $sformatf("vec%0d unf", v), DW'(stack_underflow), DW'(VECS[v].eunf));
    end

    // R3 overflow on ninth push, R9 sticky
    do_cmd(4'd12, 3'd0, '0);
    for (int k = 0; k < 8; k++) do_cmd(4'd1, 3'd0, DW'(64'h100 + k));
    rd_a_idx = 3'd7;
    #0;
    chk(3, "full stack top", DW'(top_ptr), 0);
    chk(3, "full stack no ovf", DW'(stack_overflow), 0);
    chk(2, "deepest entry", rd_a_data, 64'h100);
    rd_a_idx = 3'd0;
    do_cmd(4'd1, 3'd0, 64'h1FF);
    chk(3, "ninth push ovf", DW'(stack_overflow), 1);
    chk(3, "ninth push top", DW'(top_ptr), 7);
    chk(3, "ninth push data", rd_a_data, 64'h1FF);
    do_cmd(4'd2, 3'd0, '0);
    chk(9, "ovf sticky after pop", DW'(stack_overflow), 1);
    chk(9, "valid pop no unf", DW'(stack_underflow), 0);

    // R10 command ignored without cmd_valid
    cmd_op = 4'd1; cmd_wdata = 64'h77;
    @(negedge clk);
    chk(10, "no strobe top", DW'(top_ptr), 0);

    // R9 read strobe underflow
    do_cmd(4'd12, 3'd0, '0);
    rd_b_idx = 3'd3;
    @(negedge clk);
    chk(9, "unstrobed read no unf", DW'(stack_underflow), 0);
    chk(2, "port b empty tag", DW'(rd_b_tag), 0);
    rd_b_en = 1'b1;
    @(negedge clk);
    rd_b_en = 1'b0;
    chk(9, "strobed empty read unf", DW'(stack_underflow), 1);

    // R7 exchange with empty entry
    do_cmd(4'd12, 3'd0, '0);
    do_cmd(4'd1, 3'd0, 64'h5A);
    rd_a_idx = 3'd0; rd_b_idx = 3'd3;
    do_cmd(4'd8, 3'd3, '0);
    chk(7, "xch empty unf", DW'(stack_underflow), 1);
    chk(7, "xch top tag", DW'(rd_a_tag), 0);
    chk(7, "xch moved tag", DW'(rd_b_tag), 1);
    chk(7, "xch moved data", rd_b_data, 64'h5A);

    // R4 double pop over one empty entry
    do_cmd(4'd12, 3'd0, '0);
    do_cmd(4'd1, 3'd0, 64'h1);
    do_cmd(4'd3, 3'd0, '0);
    chk(4, "pop2 unf", DW'(stack_underflow), 1);
    chk(4, "pop2 top", DW'(top_ptr), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule